// File: doc/BRIEF.md
# Control Endpoint OUT Handshake Controller

This block holds the flags and handshake choice for the OUT data stage of a USB control transfer. The serial interface engine gives it decoded token events (SETUP, IN, OUT) and a strobe for each received data packet with its byte count. Firmware gives it a two-bit maximum-packet-size code. For every data packet the block registers a handshake choice of ACK, NAK or STALL. It also keeps an 8-bit control/status word that firmware reads, and sets bits in it by writing ones. An interrupt request pulses for one cycle whenever a flag is raised.

The endpoint enters receive mode on an OUT token. It leaves receive mode on a SETUP or IN token, or when a packet shorter than the maximum size is accepted. A zero-length packet is short in every case, so it ends a transfer whose length is an exact multiple of the maximum size. Once firmware declares the data complete, any further OUT packet gets a STALL and the stall is reported back.

Top module: `ep0_out_hs`

## Requirements
- R1: A data packet strobe (`pkt_valid`) that arrives while the ready flag (bit 0) and the data-end flag (bit 3) are both clear is accepted, with the following effects on the next clock:
  - `hs_valid` is 1 and `hs_code` is ACK (0).
  - Bit 0 of `csr_rdata` becomes 1.
  - `irq` is 1.
- R2: A CSR write with bit 6 of `csr_wdata` set clears the ready flag (bit 0) on the next clock.
- R3: A packet that arrives while bit 0 is set is answered with NAK (1). Bit 0 stays set, receive mode is unchanged and `irq` stays 0.
- R4: Token codes on `tok_kind` are SETUP = 0, IN = 1, OUT = 2; code 3 has no effect. An OUT token sets receive mode, which reads back on bit 1.
- R5: A SETUP or IN token that arrives in receive mode has the following effects on the next clock:
  - The setup-end flag (bit 4) is set.
  - `irq` pulses.
  - Receive mode clears.
  
  The same tokens outside receive mode leave bit 4 unchanged.
- R6: An accepted packet whose byte count is strictly below the maximum packet size clears receive mode. A packet of exactly the maximum size keeps receive mode.
- R7: An accepted zero-length packet clears receive mode.
- R8: Writing 1 to bit 3 sets data-end. A packet that arrives while data-end is set has the following effects on the next clock:
  - `hs_code` is STALL (2).
  - The sent-stall flag (bit 2) is set.
  - `irq` pulses.
  - Bit 0 and receive mode are unchanged.
- R9: A SETUP token clears data-end; an IN token does not. Writing 1 to bit 2 clears sent-stall and writing 1 to bit 4 clears setup-end; nothing else clears them. Bits 5 to 7 read 0.
- R10: While `rst_n` is low at a clock edge, every flag, receive mode, `irq` and `hs_valid` go to 0.
- R11: `irq` and `hs_valid` are single-cycle pulses.
- R12: `mps_sel` selects the maximum packet size: 0 gives 8 bytes, 1 gives 16, 2 gives 32 and 3 gives 64.
- R13: When an event and a firmware write land in the same cycle, the hardware set of a flag wins over a firmware clear. A SETUP token's clear of data-end wins over a firmware set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | Token code: 0 SETUP, 1 IN, 2 OUT |
| pkt_valid | input | 1 | OUT data packet received strobe |
| pkt_len | input | LEN_W | Byte count of the received packet |
| mps_sel | input | 2 | Maximum packet size code (8 << code) |
| csr_wr | input | 1 | Firmware write strobe |
| csr_wdata | input | CSR_W | Firmware write data (ones set or clear bits) |
| csr_rdata | output | CSR_W | Control/status word |
| irq | output | 1 | Interrupt request pulse |
| hs_valid | output | 1 | Handshake choice valid |
| hs_code | output | 2 | 0 ACK, 1 NAK, 2 STALL |

## Verification
The bench builds the block with its default widths: a 7-bit byte count and an 8-bit status word. It drives `mps_sel` through all four codes. This reaches the 64-byte full-packet boundary, short packets one byte below the limit, and zero-length terminations. The same flow also reaches NAK back-pressure, STALL after data-end, and premature setup ends caused by SETUP and IN tokens inside receive mode.

// File: rtl/ep0_out_pkg.sv
// ep0_out_pkg: shared encodings for the control OUT handshake controller.
// Assumes an 8-bit status word; the bit positions below are fixed by the firmware map.
package ep0_out_pkg;
    typedef enum logic [1:0] {
        TK_SETUP = 2'd0,
        TK_IN    = 2'd1,
        TK_OUT   = 2'd2,
        TK_NONE  = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2
    } hs_e;

    localparam int unsigned BIT_RDY  = 0;
    localparam int unsigned BIT_RXM  = 1;
    localparam int unsigned BIT_STL  = 2;
    localparam int unsigned BIT_DEND = 3;
    localparam int unsigned BIT_SEND = 4;
    localparam int unsigned BIT_SVC  = 6;

    // Maximum packet size in bytes for a two-bit size code.
    function automatic logic [6:0] mps_bytes(input logic [1:0] code);
        return 7'd8 << code;
    endfunction
endpackage

// File: rtl/ep0_hs_select.sv
// ep0_hs_select: picks ACK, NAK or STALL for each received OUT data packet
// and registers the choice. Assumes pkt_valid is a one-cycle strobe.
module ep0_hs_select
    import ep0_out_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_valid,
    input  logic data_end,
    input  logic rdy_flag,
    output logic accept,
    output logic stall_now,
    output logic hs_valid,
    output logic [1:0] hs_code
);
    hs_e choice;

    // Decide the handshake from the current flags.
    always_comb begin
        if (data_end)      choice = HS_STALL;
        else if (rdy_flag) choice = HS_NAK;
        else               choice = HS_ACK;
    end

    assign accept    = pkt_valid && !data_end && !rdy_flag;
    assign stall_now = pkt_valid && data_end;

    // Register the handshake toward the serial engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid <= 1'b0;
            hs_code  <= HS_ACK;
        end else begin
            hs_valid <= pkt_valid;
            if (pkt_valid) hs_code <= choice;
        end
    end

    // R3: packet during pending ready flag is refused
    a_r3_nak_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && rdy_flag && !data_end) |=> (hs_valid && hs_code == HS_NAK));

    // R11: handshake strobe never lasts two cycles without a new packet
    a_r11_hs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && !$past(pkt_valid)) |-> 1'b0);
endmodule

// File: rtl/ep0_rx_track.sv
// ep0_rx_track: keeps receive mode for the control OUT data stage and flags
// SETUP/IN tokens that arrive inside it. Tokens take priority over packets.
module ep0_rx_track
    import ep0_out_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             accept,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [1:0]       mps_sel,
    output logic             rx_mode,
    output logic             setup_tok,
    output logic             early_end
);
    localparam int MW = (LEN_W > 7) ? LEN_W : 7;

    logic ctl_tok;
    logic out_tok;
    logic short_pkt;
    logic [MW-1:0] len_ext;
    logic [MW-1:0] mps_ext;

    // Decode token classes and compare packet size with the limit.
    always_comb begin
        setup_tok = tok_valid && (tok_kind == TK_SETUP);
        ctl_tok   = tok_valid && (tok_kind == TK_SETUP || tok_kind == TK_IN);
        out_tok   = tok_valid && (tok_kind == TK_OUT);
        len_ext   = MW'(pkt_len);
        mps_ext   = MW'(mps_bytes(mps_sel));
        short_pkt = len_ext < mps_ext;
    end

    assign early_end = ctl_tok && rx_mode;

    // Update receive mode: exit on tokens or short packets, enter on OUT.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rx_mode <= 1'b0;
        else if (ctl_tok)              rx_mode <= 1'b0;
        else if (accept && short_pkt)  rx_mode <= 1'b0;
        else if (out_tok)              rx_mode <= 1'b1;
    end

    // R5: a premature end always leaves receive mode
    a_r5_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
        early_end |=> !rx_mode);

    // R7: an accepted zero-length packet ends receive mode
    a_r7_zlp_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pkt_len == '0 && !tok_valid) |=> !rx_mode);
endmodule

// File: rtl/ep0_ctl_csr.sv
// ep0_ctl_csr: holds the firmware-visible flags and the interrupt pulse.
// Hardware sets beat firmware clears; SETUP's clear of data-end beats a firmware set.
module ep0_ctl_csr
    import ep0_out_pkg::*;
#(
    parameter int CSR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             stall_now,
    input  logic             early_end,
    input  logic             setup_tok,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    output logic             rdy_flag,
    output logic             data_end,
    output logic             stall_flag,
    output logic             send_flag,
    output logic             irq
);
    logic w_svc;
    logic w_stl;
    logic w_dend;
    logic w_send;
    logic unused_wbits;

    // Decode firmware write-one bits.
    always_comb begin
        w_svc  = wr_en && wr_data[BIT_SVC];
        w_stl  = wr_en && wr_data[BIT_STL];
        w_dend = wr_en && wr_data[BIT_DEND];
        w_send = wr_en && wr_data[BIT_SEND];
    end

    assign unused_wbits = ^{wr_data[CSR_W-1], wr_data[5], wr_data[1:0]};

    // Update the flag register and raise the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_flag   <= 1'b0;
            data_end   <= 1'b0;
            stall_flag <= 1'b0;
            send_flag  <= 1'b0;
            irq        <= 1'b0;
        end else begin
            if (accept)         rdy_flag <= 1'b1;
            else if (w_svc)     rdy_flag <= 1'b0;
            if (setup_tok)      data_end <= 1'b0;
            else if (w_dend)    data_end <= 1'b1;
            if (stall_now)      stall_flag <= 1'b1;
            else if (w_stl)     stall_flag <= 1'b0;
            if (early_end)      send_flag <= 1'b1;
            else if (w_send)    send_flag <= 1'b0;
            irq <= accept || stall_now || early_end;
        end
    end

    // R1: accepted packet raises ready
    a_r1_accept_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rdy_flag);

    // R11: every interrupt has a raised flag behind it
    a_r11_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rdy_flag || stall_flag || send_flag));

    // R9: sent-stall only falls through a firmware write
    a_r9_stall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_flag && !w_stl) |=> stall_flag);
endmodule

// File: rtl/ep0_out_hs.sv
// ep0_out_hs: control endpoint OUT-stage handshake controller top.
// Ties the handshake chooser, the receive-mode tracker and the flag register together.
// Assumes decoded token strobes and one pkt_valid per received data packet.
module ep0_out_hs
    import ep0_out_pkg::*;
#(
    parameter int LEN_W = 7,
    parameter int CSR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             pkt_valid,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [1:0]       mps_sel,
    input  logic             csr_wr,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    output logic             irq,
    output logic             hs_valid,
    output logic [1:0]       hs_code
);
    logic accept, stall_now, rx_mode, setup_tok, early_end;
    logic rdy_flag, data_end, stall_flag, send_flag;

    ep0_hs_select u_hs (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid),
        .data_end(data_end), .rdy_flag(rdy_flag),
        .accept(accept), .stall_now(stall_now),
        .hs_valid(hs_valid), .hs_code(hs_code)
    );

    ep0_rx_track #(.LEN_W(LEN_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .accept(accept), .pkt_len(pkt_len), .mps_sel(mps_sel),
        .rx_mode(rx_mode), .setup_tok(setup_tok), .early_end(early_end)
    );

    ep0_ctl_csr #(.CSR_W(CSR_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .accept(accept), .stall_now(stall_now),
        .early_end(early_end), .setup_tok(setup_tok),
        .wr_en(csr_wr), .wr_data(csr_wdata),
        .rdy_flag(rdy_flag), .data_end(data_end), .stall_flag(stall_flag),
        .send_flag(send_flag), .irq(irq)
    );

    // Assemble the status word from flag and mode state.
    always_comb begin
        csr_rdata           = '0;
        csr_rdata[BIT_RDY]  = rdy_flag;
        csr_rdata[BIT_RXM]  = rx_mode;
        csr_rdata[BIT_STL]  = stall_flag;
        csr_rdata[BIT_DEND] = data_end;
        csr_rdata[BIT_SEND] = send_flag;
    end

    // R8: a STALL handshake is always reported in the sent-stall flag
    a_r8_stall_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == HS_STALL) |-> (csr_rdata[BIT_STL] && irq));

    // R9: SETUP clears data-end and receive mode
    a_r9_setup_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == TK_SETUP) |=> (!csr_rdata[BIT_DEND] && !csr_rdata[BIT_RXM]));

    // R8: a STALLed packet leaves the ready flag alone
    a_r8_stall_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && data_end) |=> (csr_rdata[BIT_RDY] == $past(rdy_flag) || $past(csr_wr)));
endmodule

// File: tb/ep0_out_hs_tb.sv
// ep0_out_hs_tb: behavioural reference model compared with the design every clock.
module ep0_out_hs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_kind = 2'd3;
    logic       pkt_valid = 1'b0;
    logic [6:0] pkt_len = '0;
    logic [1:0] mps_sel = 2'd0;
    logic       csr_wr = 1'b0;
    logic [7:0] csr_wdata = '0;
    logic [7:0] csr_rdata;
    logic       irq, hs_valid;
    logic [1:0] hs_code;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    string cur_req = "R10";

    // reference state
    bit m_rdy, m_rx, m_stl, m_de, m_se, m_irq, m_hsv;
    int m_hs;

    always #4 clk = ~clk;

    ep0_out_hs u_dut (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len), .mps_sel(mps_sel),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .irq(irq), .hs_valid(hs_valid), .hs_code(hs_code)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: run hung, got %0d cycles, expected under 20000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    function automatic bit [7:0] m_word();
        return {3'b000, m_se, m_de, m_stl, m_rx, m_rdy};
    endfunction

    task automatic cmp(input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // One clock: drive, advance the model at the edge, compare at the falling edge.
    task automatic cyc(input bit rst, input bit tv, input int tk, input bit pv,
                       input int len, input bit wr, input int wd);
        bit ctl, outt, setup, acc, stl, early;
        int mps;
        rst_n = !rst; tok_valid = tv; tok_kind = 2'(tk); pkt_valid = pv;
        pkt_len = 7'(len); csr_wr = wr; csr_wdata = 8'(wd);
        @(posedge clk);
        mps   = 8 << mps_sel;
        setup = tv && tk == 0;
        ctl   = tv && (tk == 0 || tk == 1);
        outt  = tv && tk == 2;
        acc   = pv && !m_de && !m_rdy;
        stl   = pv && m_de;
        early = ctl && m_rx;
        if (rst) begin
            {m_rdy, m_rx, m_stl, m_de, m_se, m_irq, m_hsv} = '0;
            m_hs = 0;
        end else begin
            m_hsv = pv;
            if (pv) m_hs = m_de ? 2 : (m_rdy ? 1 : 0);
            m_irq = acc || stl || early;
            if (ctl) m_rx = 0;
            else if (acc && len < mps) m_rx = 0;
            else if (outt) m_rx = 1;
            if (acc) m_rdy = 1; else if (wr && wd[6]) m_rdy = 0;
            if (stl) m_stl = 1; else if (wr && wd[2]) m_stl = 0;
            if (early) m_se = 1; else if (wr && wd[4]) m_se = 0;
            if (setup) m_de = 0; else if (wr && wd[3]) m_de = 1;
        end
        @(negedge clk);
        cmp("csr_rdata", csr_rdata, m_word());
        cmp("irq", irq, m_irq);
        cmp("hs_valid", hs_valid, m_hsv);
        if (m_hsv) cmp("hs_code", hs_code, m_hs);
        tok_valid = 0; pkt_valid = 0; csr_wr = 0;
    endtask

    task automatic idle();     cyc(0, 0, 3, 0, 0, 0, 0);  endtask
    task automatic tok(input int k);   cyc(0, 1, k, 0, 0, 0, 0); endtask
    task automatic pkt(input int n);   cyc(0, 0, 3, 1, n, 0, 0); endtask
    task automatic wr(input int d);    cyc(0, 0, 3, 0, 0, 1, d); endtask

    initial begin
        @(negedge clk);
        cur_req = "R10";
        for (int i = 0; i < 3; i++) cyc(1, 0, 3, 0, 0, 0, 0);
        idle();

        // transfer with 8-byte limit
        mps_sel = 2'd0; cur_req = "R12";
        tok(0); cur_req = "R4"; tok(2); tok(3);
        cur_req = "R1"; pkt(8); idle();
        cur_req = "R6"; idle();
        cur_req = "R3"; pkt(8); idle();
        cur_req = "R2"; wr(8'h40); idle();
        cur_req = "R6"; tok(2); pkt(7); idle();
        cur_req = "R5"; wr(8'h40); tok(1); idle();

        // 64-byte limit, exact multiple then zero-length end
        mps_sel = 2'd3; cur_req = "R12";
        tok(0); tok(2); pkt(64); idle(); wr(8'h40);
        cur_req = "R6"; tok(2); pkt(63); wr(8'h40);
        cur_req = "R7"; tok(2); pkt(64); wr(8'h40); tok(2); pkt(0); idle(); wr(8'h40);

        // 16-byte limit, IN inside receive mode
        mps_sel = 2'd1; cur_req = "R5";
        tok(0); tok(2); pkt(16); wr(8'h40); tok(1); idle();
        cur_req = "R9"; wr(8'h04); wr(8'h10); idle();

        // data-end and STALL
        cur_req = "R8";
        tok(0); tok(2); pkt(16); wr(8'h40); wr(8'h08); tok(2); pkt(5); idle();
        pkt(16); idle();
        cur_req = "R9"; tok(1); idle(); wr(8'hA0); idle(); wr(8'h04); tok(0); idle();

        // 32-byte limit, SETUP inside receive mode, same-cycle priority
        mps_sel = 2'd2; cur_req = "R5";
        tok(0); tok(2); tok(0); idle();
        cur_req = "R13";
        wr(8'h10); tok(2); pkt(32); idle();
        cyc(0, 0, 3, 1, 32, 1, 8'h40); idle();
        wr(8'h40); wr(8'h08); cyc(0, 1, 0, 0, 0, 1, 8'h08); idle();
        cur_req = "R11"; tok(2); pkt(31); idle(); idle();

        cur_req = "R10";
        wr(8'h08); cyc(1, 0, 3, 0, 0, 0, 0); idle();

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule